// File: doc/BRIEF.md
# Halfword Byte-Swap DMA Path

This block moves data between a 16-bit peripheral and system memory, where the peripheral's two byte lanes are wired in the opposite order to memory's. The peripheral posts one transfer request at a time. Each request carries a start address, a byte count, a direction and a flag that turns swapping off. The block then runs the transfer against a simple memory port. That port takes a burst command (address, byte length, direction), then halfword data beats, and then returns one acknowledge pulse per burst.

A base value from a configuration input is ORed into every request address to form the memory address. With swapping on, the address and the byte count are both rounded down to even values, and the two bytes of every halfword are exchanged in both directions. Swapped writes are also cut into bursts of at most `MAX_CHUNK` bytes. With swapping off, the data, address and count pass through unchanged as one burst. A request whose count is zero after rounding finishes at once and touches no memory. A one-cycle done pulse marks the end of every request.

Top module: `hwswap_dma`

## Requirements
- R1: After reset, `reqReady` is 1 and `memCmdValid`, `memWrValid`, `pOutValid` and `done` are 0.
- R2: The memory address of the first burst equals `reqAddr | cfgBase`. With swapping on, bit 0 of that value is then cleared.
- R3: With `reqNoSwap`=1, data passes unchanged in both directions and the burst length equals `reqLen` exactly, odd values included.
- R4: With `reqNoSwap`=0, every burst has bit 0 of both address and length at 0, and the total length equals `reqLen` with bit 0 cleared.
- R5: With swapping on, a write sends `{pInData[7:0], pInData[15:8]}` to `memWrData` for every beat.
- R6: With swapping on, a read delivers `{memRdData[7:0], memRdData[15:8]}` on `pOutData` for every beat.
- R7: A swapped write is split into bursts of `MAX_CHUNK` bytes (default 64), with the remainder last. Each burst address is the previous one plus the previous burst length.
- R8: Reads, and writes with swapping off, are issued as one burst covering the whole length.
- R9: A request whose length is 0 after rounding issues no memory command, and `done` is 1 in the cycle after it is accepted.
- R10: `done` is 1 for exactly one cycle, the cycle after the acknowledge of the last burst.
- R11: Each burst carries ceil(length/2) data beats. `reqReady` stays 0 from acceptance until the done cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgBase | input | ADDR_W | High-address base ORed into request addresses |
| reqValid | input | 1 | Transfer request present |
| reqReady | output | 1 | Block idle, request accepted |
| reqAddr | input | ADDR_W | Request start address |
| reqLen | input | LEN_W | Request length in bytes |
| reqWrite | input | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| reqNoSwap | input | 1 | 1 = pass data and geometry through unchanged |
| pInValid | input | 1 | Peripheral write halfword valid |
| pInReady | output | 1 | Peripheral write halfword taken |
| pInData | input | 16 | Peripheral write halfword |
| pOutValid | output | 1 | Read halfword valid toward peripheral |
| pOutReady | input | 1 | Peripheral takes read halfword |
| pOutData | output | 16 | Read halfword toward peripheral |
| memCmdValid | output | 1 | Burst command valid |
| memCmdReady | input | 1 | Memory accepts burst command |
| memCmdAddr | output | ADDR_W | Burst byte address |
| memCmdLen | output | LEN_W | Burst length in bytes |
| memCmdWrite | output | 1 | Burst direction, 1 = write |
| memWrValid | output | 1 | Write beat valid |
| memWrReady | input | 1 | Memory takes write beat |
| memWrData | output | 16 | Write beat data |
| memRdValid | input | 1 | Read beat valid |
| memRdReady | output | 1 | Block takes read beat |
| memRdData | input | 16 | Read beat data |
| memAck | input | 1 | One-cycle burst completion pulse |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The assertions assume that memory returns exactly the beats of each command and then one `memAck` pulse after the last beat. They also assume `memAck` never arrives while a burst still has data outstanding. The bench acts as that memory, so it keeps to these rules: it counts beats against the length of each accepted command, raises `memAck` only in the cycle after the last beat, and never drives `memRdValid` outside a read burst. The bench changes `cfgBase` only between requests and holds request fields stable while `reqValid` is high. It varies the handshake readiness on every interface with cycle-based patterns, so stalls hit commands, beats and acknowledges at different points.

// File: rtl/hwswap_dma_pkg.sv
package hwswap_dma_pkg;

  localparam int HW_BYTES = 2;
  localparam int HW_BITS  = 8 * HW_BYTES;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_XFER,
    S_WACK,
    S_FIN
  } ctrlState_e;

  // strobes sent from control to datapath
  typedef struct packed {
    logic load;      // capture a new request
    logic cmdFire;   // burst command accepted by memory
    logic beatFire;  // one data beat moved
  } ctrlStrobe_t;

endpackage

// File: rtl/hwswap_dma_lane.sv
module hwswap_dma_lane #(
  parameter int LANES = 2
) (
  input  logic                 swapOn,
  input  logic [8*LANES-1:0]   din,
  output logic [8*LANES-1:0]   dout
);

  logic [8*LANES-1:0] reversed;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign reversed[8*i +: 8] = din[8*(LANES-1-i) +: 8];
  end

  assign dout = swapOn ? reversed : din;

endmodule

// File: rtl/hwswap_dma_dp.sv
module hwswap_dma_dp
  import hwswap_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_CHUNK = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobe_t          strb,
  input  logic [ADDR_W-1:0]    cfgBase,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic                 reqWrite,
  input  logic                 reqNoSwap,
  input  logic [HW_BITS-1:0]   pInData,
  input  logic [HW_BITS-1:0]   memRdData,
  output logic [ADDR_W-1:0]    memCmdAddr,
  output logic [LEN_W-1:0]     memCmdLen,
  output logic                 isWrite,
  output logic [HW_BITS-1:0]   memWrData,
  output logic [HW_BITS-1:0]   pOutData,
  output logic                 reqLenZero,
  output logic                 remZero,
  output logic                 lastBeat,
  output logic                 swapOn
);

  localparam logic [LEN_W-1:0] CHUNK_MAX = LEN_W'(MAX_CHUNK);

  logic [ADDR_W-1:0] fullAddr;
  logic [ADDR_W-1:0] alignAddr;
  logic [LEN_W-1:0]  alignLen;
  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remLen;
  logic [LEN_W-1:0]  beatsLeft;
  logic [LEN_W-1:0]  chunkLen;
  logic [LEN_W-1:0]  chunkBeats;
  logic              chunkCap;

  // request geometry, aligned when swapping
  always_comb begin
    fullAddr  = reqAddr | cfgBase;
    alignAddr = fullAddr;
    alignLen  = reqLen;
    if (!reqNoSwap) begin
      alignAddr[0] = 1'b0;
      alignLen[0]  = 1'b0;
    end
  end

  assign reqLenZero = (alignLen == '0);

  // burst sizing: only swapped writes are bounded
  assign chunkCap   = swapOn && isWrite && (remLen > CHUNK_MAX);
  assign chunkLen   = chunkCap ? CHUNK_MAX : remLen;
  assign chunkBeats = (chunkLen >> 1) + {{(LEN_W-1){1'b0}}, chunkLen[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curAddr   <= '0;
      remLen    <= '0;
      beatsLeft <= '0;
      swapOn    <= 1'b0;
      isWrite   <= 1'b0;
    end else begin
      if (strb.load) begin
        curAddr <= alignAddr;
        remLen  <= alignLen;
        swapOn  <= !reqNoSwap;
        isWrite <= reqWrite;
      end else if (strb.cmdFire) begin
        curAddr   <= curAddr + ADDR_W'(chunkLen);
        remLen    <= remLen - chunkLen;
        beatsLeft <= chunkBeats;
      end else if (strb.beatFire) begin
        beatsLeft <= beatsLeft - 1'b1;
      end
    end
  end

  assign memCmdAddr = curAddr;
  assign memCmdLen  = chunkLen;
  assign remZero    = (remLen == '0);
  assign lastBeat   = (beatsLeft == LEN_W'(1));

  hwswap_dma_lane #(.LANES(HW_BYTES)) u_wrLane (
    .swapOn (swapOn),
    .din    (pInData),
    .dout   (memWrData)
  );

  hwswap_dma_lane #(.LANES(HW_BYTES)) u_rdLane (
    .swapOn (swapOn),
    .din    (memRdData),
    .dout   (pOutData)
  );

endmodule

// File: rtl/hwswap_dma_ctrl.sv
module hwswap_dma_ctrl
  import hwswap_dma_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  output logic         reqReady,
  input  logic         reqLenZero,
  input  logic         remZero,
  input  logic         lastBeat,
  input  logic         isWrite,
  input  logic         pInValid,
  output logic         pInReady,
  output logic         pOutValid,
  input  logic         pOutReady,
  output logic         memCmdValid,
  input  logic         memCmdReady,
  output logic         memWrValid,
  input  logic         memWrReady,
  input  logic         memRdValid,
  output logic         memRdReady,
  input  logic         memAck,
  output logic         done,
  output ctrlStrobe_t  strb
);

  ctrlState_e st, nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    nxt         = st;
    strb        = '0;
    reqReady    = 1'b0;
    memCmdValid = 1'b0;
    pInReady    = 1'b0;
    memWrValid  = 1'b0;
    memRdReady  = 1'b0;
    pOutValid   = 1'b0;
    done        = 1'b0;
    unique case (st)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.load = 1'b1;
          nxt = reqLenZero ? S_FIN : S_CMD;
        end
      end
      S_CMD: begin
        memCmdValid = 1'b1;
        if (memCmdReady) begin
          strb.cmdFire = 1'b1;
          nxt = S_XFER;
        end
      end
      S_XFER: begin
        if (isWrite) begin
          pInReady   = memWrReady;
          memWrValid = pInValid;
          if (pInValid && memWrReady) begin
            strb.beatFire = 1'b1;
            if (lastBeat) nxt = S_WACK;
          end
        end else begin
          memRdReady = pOutReady;
          pOutValid  = memRdValid;
          if (memRdValid && pOutReady) begin
            strb.beatFire = 1'b1;
            if (lastBeat) nxt = S_WACK;
          end
        end
      end
      S_WACK: begin
        if (memAck) nxt = remZero ? S_FIN : S_CMD;
      end
      S_FIN: begin
        done = 1'b1;
        nxt  = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/hwswap_dma.sv
module hwswap_dma
  import hwswap_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_CHUNK = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqWrite,
  input  logic              reqNoSwap,
  input  logic              pInValid,
  output logic              pInReady,
  input  logic [15:0]       pInData,
  output logic              pOutValid,
  input  logic              pOutReady,
  output logic [15:0]       pOutData,
  output logic              memCmdValid,
  input  logic              memCmdReady,
  output logic [ADDR_W-1:0] memCmdAddr,
  output logic [LEN_W-1:0]  memCmdLen,
  output logic              memCmdWrite,
  output logic              memWrValid,
  input  logic              memWrReady,
  output logic [15:0]       memWrData,
  input  logic              memRdValid,
  output logic              memRdReady,
  input  logic [15:0]       memRdData,
  input  logic              memAck,
  output logic              done
);

  ctrlStrobe_t strb;
  logic        reqLenZero;
  logic        remZero;
  logic        lastBeat;
  logic        swapOn;

  hwswap_dma_dp #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .MAX_CHUNK (MAX_CHUNK)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .cfgBase    (cfgBase),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .reqWrite   (reqWrite),
    .reqNoSwap  (reqNoSwap),
    .pInData    (pInData),
    .memRdData  (memRdData),
    .memCmdAddr (memCmdAddr),
    .memCmdLen  (memCmdLen),
    .isWrite    (memCmdWrite),
    .memWrData  (memWrData),
    .pOutData   (pOutData),
    .reqLenZero (reqLenZero),
    .remZero    (remZero),
    .lastBeat   (lastBeat),
    .swapOn     (swapOn)
  );

  hwswap_dma_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .reqLenZero  (reqLenZero),
    .remZero     (remZero),
    .lastBeat    (lastBeat),
    .isWrite     (memCmdWrite),
    .pInValid    (pInValid),
    .pInReady    (pInReady),
    .pOutValid   (pOutValid),
    .pOutReady   (pOutReady),
    .memCmdValid (memCmdValid),
    .memCmdReady (memCmdReady),
    .memWrValid  (memWrValid),
    .memWrReady  (memWrReady),
    .memRdValid  (memRdValid),
    .memRdReady  (memRdReady),
    .memAck      (memAck),
    .done        (done),
    .strb        (strb)
  );

endmodule

// File: rtl/hwswap_dma_chk.sv
module hwswap_dma_chk #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_CHUNK = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              reqReady,
  input logic              swapOn,
  input logic              pInValid,
  input logic [15:0]       pInData,
  input logic              pOutValid,
  input logic [15:0]       pOutData,
  input logic              memCmdValid,
  input logic              memCmdReady,
  input logic [ADDR_W-1:0] memCmdAddr,
  input logic [LEN_W-1:0]  memCmdLen,
  input logic              memCmdWrite,
  input logic              memWrValid,
  input logic [15:0]       memWrData,
  input logic              memRdValid,
  input logic [15:0]       memRdData,
  input logic              done
);

  // R11: accepting a request makes the block busy
  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady |=> !reqReady);

  // R4: swapped bursts are halfword aligned
  p_even_geometry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    memCmdValid && swapOn |-> !memCmdAddr[0] && !memCmdLen[0]);

  // R7: swapped write bursts stay within the chunk bound
  p_chunk_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    memCmdValid && swapOn && memCmdWrite |-> memCmdLen <= LEN_W'(MAX_CHUNK));

  // R7: a stalled command holds its fields
  p_cmd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    memCmdValid && !memCmdReady |=> memCmdValid && $stable(memCmdAddr) && $stable(memCmdLen));

  // R10: done lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: write lanes exchanged when swapping
  p_wr_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    memWrValid && swapOn |-> pInValid && memWrData == {pInData[7:0], pInData[15:8]});

  // R3: read data untouched without swapping
  p_rd_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pOutValid && !swapOn |-> memRdValid && pOutData == memRdData);

endmodule

bind hwswap_dma hwswap_dma_chk #(
  .ADDR_W    (ADDR_W),
  .LEN_W     (LEN_W),
  .MAX_CHUNK (MAX_CHUNK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .swapOn      (swapOn),
  .pInValid    (pInValid),
  .pInData     (pInData),
  .pOutValid   (pOutValid),
  .pOutData    (pOutData),
  .memCmdValid (memCmdValid),
  .memCmdReady (memCmdReady),
  .memCmdAddr  (memCmdAddr),
  .memCmdLen   (memCmdLen),
  .memCmdWrite (memCmdWrite),
  .memWrValid  (memWrValid),
  .memWrData   (memWrData),
  .memRdValid  (memRdValid),
  .memRdData   (memRdData),
  .done        (done)
);

// File: tb/hwswap_dma_tb.sv
`timescale 1ns/1ps
module hwswap_dma_tb;

  localparam int AW = 32;
  localparam int LW = 16;
  localparam int MAXC = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] cfgBase = '0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqNoSwap = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [LW-1:0] reqLen = '0;
  logic pInValid = 1'b0, pOutReady = 1'b0, memCmdReady = 1'b0;
  logic memWrReady = 1'b0, memRdValid = 1'b0, memAck = 1'b0;
  logic [15:0] pInData = '0, memRdData = '0;
  logic reqReady, pInReady, pOutValid, memCmdValid, memCmdWrite;
  logic memWrValid, memRdReady, done;
  logic [15:0] pOutData, memWrData;
  logic [AW-1:0] memCmdAddr;
  logic [LW-1:0] memCmdLen;

  always #2 clk = ~clk;

  hwswap_dma #(.ADDR_W(AW), .LEN_W(LW), .MAX_CHUNK(MAXC)) u_dut (.*);

  typedef struct { logic [AW-1:0] a; int len; bit wr; bit ns; } req_t;
  typedef struct { logic [AW-1:0] a; int len; bit wr; } cmd_t;

  req_t reqQ[$];
  cmd_t expCmdQ[$];
  logic [15:0] pinQ[$];
  logic [15:0] expWrQ[$];

  int checks = 0, failures = 0, cyc = 0;
  int burstLeft = 0, rdLeft = 0;
  bit busy = 0, curSwap = 0, ackNext = 0, ackNextLast = 0, ackLast = 0;
  bit doneNext = 0, watchdogHit = 0;
  int seed = 1;

  function automatic logic [15:0] bs(input logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic acceptReq(input req_t r);
    logic [AW-1:0] a;
    int len, rem, c, beats;
    a = r.a | cfgBase;
    len = r.len;
    if (!r.ns) begin a[0] = 1'b0; len = len & ~1; end
    busy = 1;
    curSwap = !r.ns;
    if (len == 0) begin doneNext = 1; return; end
    rem = len;
    while (rem > 0) begin
      c = (!r.ns && r.wr && rem > MAXC) ? MAXC : rem;
      expCmdQ.push_back('{a: a, len: c, wr: r.wr});
      if (r.wr) begin
        beats = (c + 1) / 2;
        for (int k = 0; k < beats; k++) begin
          logic [15:0] v;
          seed = seed * 1103515245 + 12345;
          v = 16'(seed >>> 8);
          pinQ.push_back(v);
          expWrQ.push_back(r.ns ? v : bs(v));
        end
      end
      a = a + AW'(c);
      rem = rem - c;
    end
  endtask

  task automatic step();
    cmd_t ec;
    @(negedge clk);
    cyc++;
    memCmdReady = (cyc % 3) != 0;
    memWrReady  = (cyc % 4) != 1;
    pOutReady   = (cyc % 5) != 2;
    pInValid    = (pinQ.size() > 0) && ((cyc % 3) != 1);
    pInData     = (pinQ.size() > 0) ? pinQ[0] : 16'h0;
    memRdValid  = (rdLeft > 0) && ((cyc % 2) == 0);
    memRdData   = 16'h5A00 ^ 16'(cyc * 37);
    memAck      = ackNext;
    ackLast     = ackNextLast;
    ackNext     = 0;
    ackNextLast = 0;
    reqValid    = reqQ.size() > 0;
    if (reqQ.size() > 0) begin
      reqAddr = reqQ[0].a; reqLen = LW'(reqQ[0].len);
      reqWrite = reqQ[0].wr; reqNoSwap = reqQ[0].ns;
    end
    #1;
    // R11: no acceptance while busy
    if (busy) chk(!reqReady, "R11 reqReady while busy", reqReady, 0);
    // R9 R10: done timing
    if (doneNext) begin
      chk(done === 1'b1, "R10 done pulse", done, 1);
      doneNext = 0;
      busy = 0;
    end else if (done) begin
      chk(0, "R10 spurious done", done, 0);
    end
    if (memAck && ackLast) doneNext = 1;
    if (reqValid && reqReady) begin
      req_t r;
      r = reqQ.pop_front();
      acceptReq(r);
    end
    if (memCmdValid && memCmdReady) begin
      if (expCmdQ.size() == 0) begin
        chk(0, "R9 unexpected command", memCmdAddr, 0);
      end else begin
        ec = expCmdQ.pop_front();
        chk(memCmdAddr == ec.a, "R2 R7 command address", memCmdAddr, ec.a);
        chk(int'(memCmdLen) == ec.len, "R3 R4 R7 R8 command length", memCmdLen, ec.len);
        chk(memCmdWrite == ec.wr, "R8 command direction", memCmdWrite, ec.wr);
        burstLeft = (ec.len + 1) / 2;
        if (!ec.wr) rdLeft = burstLeft;
      end
    end
    if (memWrValid && memWrReady) begin
      if (burstLeft == 0 || expWrQ.size() == 0) begin
        chk(0, "R11 extra write beat", memWrData, 0);
      end else begin
        logic [15:0] ew;
        ew = expWrQ.pop_front();
        chk(pInReady && pInValid, "R11 write handshake pairing", pInReady, 1);
        void'(pinQ.pop_front());
        chk(memWrData == ew, curSwap ? "R5 write data" : "R3 write data", memWrData, ew);
        burstLeft--;
        if (burstLeft == 0) begin ackNext = 1; ackNextLast = (expCmdQ.size() == 0); end
      end
    end
    if (memRdValid && memRdReady) begin
      logic [15:0] er;
      er = curSwap ? bs(memRdData) : memRdData;
      chk(pOutValid, "R11 read valid pass", pOutValid, 1);
      chk(pOutData == er, curSwap ? "R6 read data" : "R3 read data", pOutData, er);
      burstLeft--;
      rdLeft--;
      if (burstLeft == 0) begin ackNext = 1; ackNextLast = (expCmdQ.size() == 0); end
    end
  endtask

  task automatic runReq(input logic [AW-1:0] base, input logic [AW-1:0] a,
                        input int len, input bit wr, input bit ns);
    int n;
    cfgBase = base;
    reqQ.push_back('{a: a, len: len, wr: wr, ns: ns});
    n = 0;
    do begin
      step();
      n++;
    end while ((reqQ.size() > 0 || busy || doneNext) && n < 3000);
    if (n >= 3000) begin
      watchdogHit = 1;
      chk(0, "watchdog R10 request never finished", n, 0);
      reqQ.delete();
      busy = 0;
    end
    chk(expCmdQ.size() == 0, "R7 R8 all commands issued", expCmdQ.size(), 0);
    chk(expWrQ.size() == 0, "R11 all write beats moved", expWrQ.size(), 0);
    reqValid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(reqReady == 1'b1, "R1 reqReady after reset", reqReady, 1);
    chk(memCmdValid == 1'b0, "R1 memCmdValid after reset", memCmdValid, 0);
    chk(memWrValid == 1'b0 && pOutValid == 1'b0, "R1 data valids after reset", memWrValid, 0);
    chk(done == 1'b0, "R1 done after reset", done, 0);

    runReq(32'h00F0_0000, 32'h0000_1003, 7, 1, 1);    // R3 R2 odd no-swap write
    runReq(32'h0030_0000, 32'h0000_0205, 10, 0, 1);   // R3 R8 no-swap read
    runReq(32'h0000_0000, 32'h0000_2001, 150, 1, 0);  // R7 R4 R5 split write
    runReq(32'h0100_0000, 32'h0000_0040, 64, 1, 0);   // R7 exact chunk
    runReq(32'h0000_0000, 32'h0000_3003, 131, 0, 0);  // R6 R8 swapped read
    runReq(32'h0000_0000, 32'h0000_0100, 1, 1, 0);    // R9 aligned to zero
    runReq(32'h0000_0000, 32'h0000_0100, 0, 0, 1);    // R9 zero no-swap
    runReq(32'h0000_0000, 32'h0000_4000, 129, 1, 0);  // R7 two full chunks
    runReq(32'h0000_0001, 32'h0000_0010, 6, 1, 0);    // R2 base bit0 cleared
    runReq(32'h0000_0001, 32'h0000_0010, 6, 0, 1);    // R2 base bit0 kept
    runReq(32'h0000_0000, 32'h0000_5000, 200, 1, 1);  // R8 long no-swap write
    // back-to-back requests, R11
    cfgBase = 32'h0;
    reqQ.push_back('{a: 32'h6000, len: 4, wr: 1, ns: 0});
    runReq(32'h0, 32'h7001, 70, 1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #700000;
    failures++;
    checks++;
    $display("FAIL watchdog R10 global timeout actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule